// File: doc/BRIEF.md
# Six-opcode multicycle processor core

This block is a small 16-bit programmable core built from a control unit and a datapath. The control unit holds the program counter, the instruction register and a finite state machine that steps every instruction through fetch, decode and one execute state. The datapath holds a sixteen-entry register file with two read ports and one write port, an ALU that can pass, add or subtract, a three-way write-back selector and a zero detector on the first read port.

The core drives an instruction-memory port and a 256-word data-memory port. Both memories answer a read combinationally in the same cycle, and a data-memory write lands at the clock edge that ends the execute cycle. Instructions are 16 bits wide, with the opcode in bits [15:12]. Register fields are 4 bits wide. Addresses, constants and jump offsets use the low 8 bits.

Top module: `sixop_core`

## Requirements
- R1: While rst_n is low, imem_rd, dmem_rd and dmem_wr are 0 and imem_addr is 0. After release, the core spends one Init cycle and fetches address 0 in the second cycle.
- R2: A fetch cycle raises imem_rd for one cycle at imem_addr = PC and advances PC by 1. It is followed by a decode cycle and one execute cycle, so an ordinary instruction takes 3 cycles and the next fetch comes 3 cycles after the previous one.
- R3: Load (opcode 0000, register a in [11:8], address d in [7:0]) raises dmem_rd with dmem_addr = d in its execute cycle and writes the returned word into register a.
- R4: Store (opcode 0001, same fields as load) raises dmem_wr for exactly its execute cycle, with dmem_addr = d and dmem_wdata equal to register a.
- R5: Add (opcode 0010, a in [11:8], b in [7:4], c in [3:0]) writes reg[b] + reg[c] modulo 2^16 into reg[a].
- R6: Subtract (opcode 0100, same fields as add) writes reg[b] - reg[c] modulo 2^16 into reg[a].
- R7: Load-constant (opcode 0011, a in [11:8]) writes bits [7:0] into reg[a], sign-extended to 16 bits as a two's-complement value.
- R8: Jump-if-zero (opcode 0101, a in [11:8], offset in [7:0]) takes 4 cycles when reg[a] is 0, and the next fetch is then at the jump's own address plus the sign-extended offset. When reg[a] is not 0 it takes 3 cycles and the next fetch is at the following address.
- R9: Opcodes 0110 to 1111 change no register and make no data-memory access. The next fetch is at the following address, two cycles after the fetch of the unused opcode.
- R10: Reset clears every register to 0.
- R11: At most one of imem_rd, dmem_rd and dmem_wr is high in any cycle.
- R12: An add or subtract whose destination is also a source reads the value the register held before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Instruction address (current PC) |
| imem_rd | output | 1 | Instruction read strobe, high in fetch cycles |
| imem_data | input | 16 | Instruction word returned in the same cycle |
| dmem_addr | output | 8 | Data-memory word address |
| dmem_rd | output | 1 | Data-memory read strobe |
| dmem_wr | output | 1 | Data-memory write strobe, the write lands at the clock edge |
| dmem_wdata | output | 16 | Data written by a store |
| dmem_rdata | input | 16 | Data returned for a read in the same cycle |

## Verification
A corrupted register shows at the ports only when a later store writes it out, or when a jump tests it and the fetch address goes somewhere else. The bench therefore runs programs that store their results often, and it predicts the cycle, the address and the PC of every data-memory access. A control-state fault, such as a lost decode cycle, a jump taken when it should not be, or an unused opcode that takes the wrong path, moves every later access by at least one cycle. It is therefore caught at the next load or store. A bad register value is caught at the first store of that register, which comes within a few instructions in each program.

// File: rtl/sixop_pkg.sv
package sixop_pkg;
   // instruction word layout (fixed by the instruction format)
   localparam int INSTR_W = 16;
   localparam int OPC_W   = 4;
   localparam int FLD_W   = 4;
   localparam int IMM_W   = 8;
   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RA_LSB  = OPC_LSB - FLD_W;
   localparam int RB_LSB  = RA_LSB - FLD_W;
   localparam int RC_LSB  = RB_LSB - FLD_W;

   // opcode values
   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0000;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'b0001;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0010;
   localparam logic [OPC_W-1:0] OPC_LDC   = 4'b0011;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0100;
   localparam logic [OPC_W-1:0] OPC_JMPZ  = 4'b0101;

   typedef enum logic [1:0] {
      ALU_PASS = 2'b00,
      ALU_ADD  = 2'b01,
      ALU_SUB  = 2'b10
   } alu_sel_e;

   typedef enum logic [1:0] {
      WB_ALU   = 2'b00,
      WB_MEM   = 2'b01,
      WB_CONST = 2'b10
   } wb_sel_e;

   typedef enum logic [3:0] {
      S_INIT, S_FETCH, S_DECODE, S_LOAD, S_STORE,
      S_ADD, S_LDC, S_SUB, S_JTEST, S_JTAKE
   } state_e;
endpackage

// File: rtl/sixop_regfile.sv
module sixop_regfile #(
   parameter  int DATA_W = 16,
   parameter  int NREG   = 16,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  paddr,
   input  logic [IDX_W-1:0]  qaddr,
   output logic [DATA_W-1:0] pdata,
   output logic [DATA_W-1:0] qdata
);
   logic [DATA_W-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (waddr == IDX_W'(g)))
            q <= wdata;
      end
      assign regs[g] = q;
   end

   assign pdata = regs[paddr];
   assign qdata = regs[qaddr];
endmodule

// File: rtl/sixop_alu.sv
module sixop_alu
   import sixop_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_sel_e          sel,
   output logic [DATA_W-1:0] y
);
   logic [DATA_W-1:0] arith;

   if (SHARED_ADDER) begin : g_shared
      // one carry chain: subtract as a + ~b + 1
      logic neg;
      assign neg   = (sel == ALU_SUB);
      assign arith = a + (b ^ {DATA_W{neg}}) + DATA_W'(neg);
   end else begin : g_split
      logic [DATA_W-1:0] sum, diff;
      assign sum   = a + b;
      assign diff  = a - b;
      assign arith = (sel == ALU_SUB) ? diff : sum;
   end

   always_comb begin
      case (sel)
         ALU_ADD, ALU_SUB: y = arith;
         default:          y = a;
      endcase
   end
endmodule

// File: rtl/sixop_dpath.sv
module sixop_dpath
   import sixop_pkg::*;
#(
   parameter  int DATA_W       = 16,
   parameter  int NREG         = 16,
   parameter  bit SHARED_ADDER = 1'b1,
   localparam int IDX_W        = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rf_wr,
   input  logic [IDX_W-1:0]  rf_waddr,
   input  logic [IDX_W-1:0]  rf_paddr,
   input  logic [IDX_W-1:0]  rf_qaddr,
   input  wb_sel_e           wb_sel,
   input  alu_sel_e          alu_sel,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] pdata,
   output logic              p_zero
);
   logic [DATA_W-1:0] qdata, alu_y, wdata, imm_ext;

   sixop_regfile #(.DATA_W(DATA_W), .NREG(NREG)) i_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (rf_wr),
      .waddr (rf_waddr),
      .wdata (wdata),
      .paddr (rf_paddr),
      .qaddr (rf_qaddr),
      .pdata (pdata),
      .qdata (qdata)
   );

   sixop_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) i_alu (
      .a   (pdata),
      .b   (qdata),
      .sel (alu_sel),
      .y   (alu_y)
   );

   assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

   always_comb begin
      case (wb_sel)
         WB_MEM:   wdata = mem_rdata;
         WB_CONST: wdata = imm_ext;
         default:  wdata = alu_y;
      endcase
   end

   assign p_zero = ~|pdata;
endmodule

// File: rtl/sixop_ctrl.sv
module sixop_ctrl
   import sixop_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int IDX_W   = 4,
   parameter int DADDR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PC_W-1:0]    imem_addr,
   output logic               imem_rd,
   input  logic [INSTR_W-1:0] imem_data,
   output logic [DADDR_W-1:0] dmem_addr,
   output logic               dmem_rd,
   output logic               dmem_wr,
   output logic               rf_wr,
   output logic [IDX_W-1:0]   rf_waddr,
   output logic [IDX_W-1:0]   rf_paddr,
   output logic [IDX_W-1:0]   rf_qaddr,
   output wb_sel_e            wb_sel,
   output alu_sel_e           alu_sel,
   output logic [IMM_W-1:0]   imm,
   input  logic               p_zero,
   output state_e             st_o
);
   state_e             st, st_nx;
   logic [PC_W-1:0]    pc, off_ext;
   logic [INSTR_W-1:0] ir;
   logic [OPC_W-1:0]   opc;
   logic [IDX_W-1:0]   fa, fb, fc;

   assign opc     = ir[OPC_LSB +: OPC_W];
   assign fa      = ir[RA_LSB +: IDX_W];
   assign fb      = ir[RB_LSB +: IDX_W];
   assign fc      = ir[RC_LSB +: IDX_W];
   assign imm     = ir[IMM_W-1:0];
   assign off_ext = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};

   always_comb begin
      case (st)
         S_FETCH:  st_nx = S_DECODE;
         S_DECODE: begin
            case (opc)
               OPC_LOAD:  st_nx = S_LOAD;
               OPC_STORE: st_nx = S_STORE;
               OPC_ADD:   st_nx = S_ADD;
               OPC_LDC:   st_nx = S_LDC;
               OPC_SUB:   st_nx = S_SUB;
               OPC_JMPZ:  st_nx = S_JTEST;
               default:   st_nx = S_FETCH;
            endcase
         end
         S_JTEST:  st_nx = p_zero ? S_JTAKE : S_FETCH;
         default:  st_nx = S_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_INIT;
         pc <= '0;
         ir <= '0;
      end else begin
         st <= st_nx;
         case (st)
            S_INIT:  pc <= '0;
            S_FETCH: begin
               ir <= imem_data;
               pc <= pc + PC_W'(1);
            end
            // fetch already advanced pc, so take one back
            S_JTAKE: pc <= pc + off_ext - PC_W'(1);
            default: ;
         endcase
      end
   end

   always_comb begin
      imem_rd  = 1'b0;
      dmem_rd  = 1'b0;
      dmem_wr  = 1'b0;
      rf_wr    = 1'b0;
      rf_waddr = fa;
      rf_paddr = fa;
      rf_qaddr = fc;
      wb_sel   = WB_ALU;
      alu_sel  = ALU_PASS;
      case (st)
         S_FETCH: imem_rd = 1'b1;
         S_LOAD: begin
            dmem_rd = 1'b1;
            wb_sel  = WB_MEM;
            rf_wr   = 1'b1;
         end
         S_STORE: dmem_wr = 1'b1;
         S_ADD: begin
            rf_paddr = fb;
            alu_sel  = ALU_ADD;
            rf_wr    = 1'b1;
         end
         S_SUB: begin
            rf_paddr = fb;
            alu_sel  = ALU_SUB;
            rf_wr    = 1'b1;
         end
         S_LDC: begin
            wb_sel = WB_CONST;
            rf_wr  = 1'b1;
         end
         default: ;
      endcase
   end

   assign imem_addr = pc;
   assign dmem_addr = ir[DADDR_W-1:0];
   assign st_o      = st;
endmodule

// File: rtl/sixop_core.sv
module sixop_core
   import sixop_pkg::*;
#(
   parameter  int DATA_W       = 16,
   parameter  int PC_W         = 16,
   parameter  int NREG         = 16,
   parameter  int DADDR_W      = 8,
   parameter  bit SHARED_ADDER = 1'b1,
   localparam int IDX_W        = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PC_W-1:0]    imem_addr,
   output logic               imem_rd,
   input  logic [INSTR_W-1:0] imem_data,
   output logic [DADDR_W-1:0] dmem_addr,
   output logic               dmem_rd,
   output logic               dmem_wr,
   output logic [DATA_W-1:0]  dmem_wdata,
   input  logic [DATA_W-1:0]  dmem_rdata
);
   // elaboration-time parameter checks against the fixed instruction format
   if (IDX_W != FLD_W) begin : g_bad_nreg
      $error("NREG must match the 4-bit register fields");
   end
   if (DADDR_W != IMM_W) begin : g_bad_daddr
      $error("DADDR_W must match the 8-bit address field");
   end
   if (DATA_W < INSTR_W) begin : g_bad_data
      $error("DATA_W must be at least the instruction width");
   end
   if (PC_W < IMM_W) begin : g_bad_pc
      $error("PC_W must hold the sign-extended jump offset");
   end

   logic             rf_wr, p_zero;
   logic [IDX_W-1:0] rf_waddr, rf_paddr, rf_qaddr;
   wb_sel_e          wb_sel;
   alu_sel_e         alu_sel;
   logic [IMM_W-1:0] imm;
   state_e           ctrl_st;

   sixop_ctrl #(.PC_W(PC_W), .IDX_W(IDX_W), .DADDR_W(DADDR_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .imem_addr (imem_addr),
      .imem_rd   (imem_rd),
      .imem_data (imem_data),
      .dmem_addr (dmem_addr),
      .dmem_rd   (dmem_rd),
      .dmem_wr   (dmem_wr),
      .rf_wr     (rf_wr),
      .rf_waddr  (rf_waddr),
      .rf_paddr  (rf_paddr),
      .rf_qaddr  (rf_qaddr),
      .wb_sel    (wb_sel),
      .alu_sel   (alu_sel),
      .imm       (imm),
      .p_zero    (p_zero),
      .st_o      (ctrl_st)
   );

   sixop_dpath #(.DATA_W(DATA_W), .NREG(NREG), .SHARED_ADDER(SHARED_ADDER)) i_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .rf_wr     (rf_wr),
      .rf_waddr  (rf_waddr),
      .rf_paddr  (rf_paddr),
      .rf_qaddr  (rf_qaddr),
      .wb_sel    (wb_sel),
      .alu_sel   (alu_sel),
      .imm       (imm),
      .mem_rdata (dmem_rdata),
      .pdata     (dmem_wdata),
      .p_zero    (p_zero)
   );
endmodule

// File: rtl/sixop_chk.sv
module sixop_chk
   import sixop_pkg::*;
#(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            imem_rd,
   input logic [PC_W-1:0] imem_addr,
   input logic            dmem_rd,
   input logic            dmem_wr,
   input state_e          st
);
   // R1: idle strobes and PC at zero while reset is held
   always @(posedge clk) begin
      if (rst_n === 1'b0) begin
         a_r1_idle_in_reset: assert (!imem_rd && !dmem_rd && !dmem_wr && imem_addr == '0);
      end
   end

   // R1: Init is followed by a fetch of address 0
   a_r1_init_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_INIT |=> (imem_rd && imem_addr == '0));

   // R2: a fetch advances the PC by one
   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      imem_rd |=> imem_addr == $past(imem_addr) + PC_W'(1));

   // R2: a fetch is followed by a quiet decode cycle
   a_r2_decode_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      imem_rd |=> (!imem_rd && !dmem_rd && !dmem_wr && st == S_DECODE));

   // R3: a load execute is followed by a fetch
   a_r3_load_returns: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_rd |=> imem_rd);

   // R4: a store strobe lasts one cycle and is followed by a fetch
   a_r4_store_returns: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_wr |=> (imem_rd && !dmem_wr));

   // R8: outside fetch, Init and the jump-take step the PC holds
   a_r8_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!imem_rd && st != S_JTAKE && st != S_INIT) |=> imem_addr == $past(imem_addr));

   // R11: memory strobes are mutually exclusive
   a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({imem_rd, dmem_rd, dmem_wr}) <= 1);
endmodule

bind sixop_core sixop_chk #(.PC_W(PC_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imem_rd   (imem_rd),
   .imem_addr (imem_addr),
   .dmem_rd   (dmem_rd),
   .dmem_wr   (dmem_wr),
   .st        (ctrl_st)
);

// File: tb/test_sixop_core.sv
module test_sixop_core;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 20000;

   typedef struct {
      bit          is_wr;
      logic [7:0]  addr;
      logic [15:0] data;
      int          cyc;
      logic [15:0] pc;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] imem_addr, imem_data, dmem_wdata, dmem_rdata;
   logic        imem_rd, dmem_rd, dmem_wr;
   logic [7:0]  dmem_addr;

   logic [15:0] prog [64];
   logic [15:0] dm   [256];
   ev_t         exp_q [$];
   int          cyc;
   int          n_chk = 0;
   int          n_err = 0;
   int          last_cyc;
   string       tag;
   bit          seen_fetch;

   sixop_core i_sixop_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rd    (imem_rd),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_rd    (dmem_rd),
      .dmem_wr    (dmem_wr),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   assign imem_data  = prog[imem_addr[5:0]];
   assign dmem_rdata = dm[dmem_addr];

   always @(posedge clk) begin
      if (dmem_wr) dm[dmem_addr] <= dmem_wdata;
   end

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // instruction encoders
   function automatic logic [15:0] i_ld(input logic [3:0] a, input logic [7:0] d);
      return {4'b0000, a, d};
   endfunction
   function automatic logic [15:0] i_st(input logic [3:0] a, input logic [7:0] d);
      return {4'b0001, a, d};
   endfunction
   function automatic logic [15:0] i_add(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
      return {4'b0010, a, b, c};
   endfunction
   function automatic logic [15:0] i_ldc(input logic [3:0] a, input logic [7:0] k);
      return {4'b0011, a, k};
   endfunction
   function automatic logic [15:0] i_sub(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
      return {4'b0100, a, b, c};
   endfunction
   function automatic logic [15:0] i_jz(input logic [3:0] a, input logic [7:0] off);
      return {4'b0101, a, off};
   endfunction

   // driver: walks the program from the requirements and queues every data access
   task automatic predict();
      logic [15:0] mr [16];
      logic [15:0] md [256];
      logic [15:0] pc, ins;
      logic [3:0]  a, b, c;
      int          k;
      for (int i = 0; i < 16; i++)  mr[i] = '0;   // R10
      for (int i = 0; i < 256; i++) md[i] = dm[i];
      pc = '0;
      k  = 1;                                      // R1: first fetch in cycle 1
      for (int step = 0; step < 400; step++) begin
         ins = prog[pc[5:0]];
         a = ins[11:8]; b = ins[7:4]; c = ins[3:0];
         case (ins[15:12])
            4'b0000: begin   // R3
               exp_q.push_back('{1'b0, ins[7:0], 16'h0, k + 2, pc + 16'd1});
               mr[a] = md[ins[7:0]];
               pc = pc + 16'd1; k = k + 3;
            end
            4'b0001: begin   // R4
               exp_q.push_back('{1'b1, ins[7:0], mr[a], k + 2, pc + 16'd1});
               md[ins[7:0]] = mr[a];
               pc = pc + 16'd1; k = k + 3;
            end
            4'b0010: begin mr[a] = mr[b] + mr[c]; pc = pc + 16'd1; k = k + 3; end  // R5
            4'b0011: begin mr[a] = {{8{ins[7]}}, ins[7:0]}; pc = pc + 16'd1; k = k + 3; end  // R7
            4'b0100: begin mr[a] = mr[b] - mr[c]; pc = pc + 16'd1; k = k + 3; end  // R6
            4'b0101: begin   // R8
               if (mr[a] == 16'h0) begin
                  if (ins[7:0] == 8'h0) break;   // self-loop ends the program
                  pc = pc + {{8{ins[7]}}, ins[7:0]};
                  k = k + 4;
               end else begin
                  pc = pc + 16'd1; k = k + 3;
               end
            end
            default: begin pc = pc + 16'd1; k = k + 2; end   // R9
         endcase
      end
      last_cyc = k;
   endtask

   // monitor: pops the expected accesses as the core makes them
   always @(negedge clk) begin
      ev_t ev;
      if (!rst_n) begin
         seen_fetch = 1'b0;
      end else begin
         if (imem_rd && !seen_fetch) begin
            seen_fetch = 1'b1;
            check(cyc == 1 && imem_addr == 16'h0, "R1", "first fetch cycle/addr",
                  {cyc[15:0], imem_addr}, 32'h0001_0000);
         end
         if (dmem_rd || dmem_wr) begin
            check(!imem_rd && !(dmem_rd && dmem_wr), "R11", "strobes",
                  {29'h0, imem_rd, dmem_rd, dmem_wr}, 32'h0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected data access at addr", {24'h0, dmem_addr}, 32'h0);
            end else begin
               ev = exp_q.pop_front();
               check(dmem_wr == ev.is_wr && dmem_addr == ev.addr, ev.is_wr ? "R4" : "R3",
                     "kind/addr", {23'h0, dmem_wr, dmem_addr}, {23'h0, ev.is_wr, ev.addr});
               check(cyc == ev.cyc, "R2", "access cycle", cyc, ev.cyc);
               check(imem_addr == ev.pc, "R8", "pc at access", {16'h0, imem_addr}, {16'h0, ev.pc});
               if (ev.is_wr)
                  check(dmem_wdata == ev.data, tag, "store data",
                        {16'h0, dmem_wdata}, {16'h0, ev.data});
            end
         end
      end
   end

   task automatic run_prog();
      predict();
      @(negedge clk);
      rst_n = 1'b1;
      while (cyc < last_cyc + 12) @(negedge clk);
      check(exp_q.size() == 0, "R2", "accesses left over", exp_q.size(), 0);
      exp_q.delete();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: idle outputs under reset
      check(!imem_rd && !dmem_rd && !dmem_wr && imem_addr == 16'h0, "R1", "reset outputs",
            {imem_addr, 13'h0, imem_rd, dmem_rd, dmem_wr}, 32'h0);
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 64; i++) prog[i] = i_jz(4'd15, 8'h00);   // R15 stays 0: halt
   endtask

   initial begin
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) dm[i] = 16'h0;
      repeat (3) @(negedge clk);
      check(!imem_rd && !dmem_rd && !dmem_wr && imem_addr == 16'h0, "R1", "reset outputs",
            {imem_addr, 13'h0, imem_rd, dmem_rd, dmem_wr}, 32'h0);

      // program 1: loads, adds, wraparound, destination used as source (R3 R4 R5 R12)
      tag = "R5,R12";
      clear_prog();
      dm[0] = 16'd99; dm[1] = 16'd102; dm[2] = 16'hFFFF;
      prog[0] = i_ld(4'd0, 8'd0);
      prog[1] = i_ld(4'd1, 8'd1);
      prog[2] = i_add(4'd2, 4'd0, 4'd1);
      prog[3] = i_st(4'd2, 8'd9);             // 201
      prog[4] = i_ld(4'd3, 8'd2);
      prog[5] = i_add(4'd3, 4'd3, 4'd1);      // wraps to 101
      prog[6] = i_st(4'd3, 8'd10);
      prog[7] = i_add(4'd0, 4'd0, 4'd0);      // 198
      prog[8] = i_st(4'd0, 8'd11);
      run_prog();

      // program 2: forward jumps taken and not, backward loop (R7 R8)
      tag = "R8";
      clear_prog();
      dm[4] = 16'd7; dm[5] = 16'd0;
      prog[0]  = i_ldc(4'd0, 8'd0);
      prog[1]  = i_ldc(4'd1, 8'd1);
      prog[2]  = i_ld(4'd2, 8'd4);
      prog[3]  = i_jz(4'd2, 8'd2);            // not taken
      prog[4]  = i_add(4'd0, 4'd0, 4'd1);
      prog[5]  = i_ld(4'd2, 8'd5);
      prog[6]  = i_jz(4'd2, 8'd2);            // taken to 8
      prog[7]  = i_add(4'd0, 4'd0, 4'd1);
      prog[8]  = i_st(4'd0, 8'd9);            // 1
      prog[9]  = i_ldc(4'd4, 8'd3);
      prog[10] = i_ldc(4'd5, 8'hFF);          // R7: -1
      prog[11] = i_add(4'd4, 4'd4, 4'd5);
      prog[12] = i_st(4'd4, 8'd20);           // 2, 1, 0
      prog[13] = i_jz(4'd4, 8'd2);
      prog[14] = i_jz(4'd15, 8'hFD);          // back to 11
      prog[15] = i_st(4'd5, 8'd21);           // FFFF
      run_prog();

      // program 3: reset clears registers, subtract, constants, unused opcodes (R6 R7 R9 R10)
      tag = "R6,R7,R9,R10";
      clear_prog();
      prog[0]  = i_st(4'd3, 8'd30);           // R10: 0
      prog[1]  = i_ldc(4'd6, 8'h7F);
      prog[2]  = i_ldc(4'd7, 8'h80);          // FF80
      prog[3]  = i_sub(4'd8, 4'd6, 4'd7);     // 00FF
      prog[4]  = i_st(4'd8, 8'd31);
      prog[5]  = i_sub(4'd9, 4'd7, 4'd6);     // FF01
      prog[6]  = i_st(4'd9, 8'd32);
      prog[7]  = 16'h6123;                    // R9: unused
      prog[8]  = 16'hF1FF;                    // R9: unused
      prog[9]  = i_st(4'd6, 8'd33);           // 007F
      prog[10] = i_st(4'd1, 8'd34);           // 0
      prog[11] = i_st(4'd2, 8'd35);           // R10: 0
      run_prog();

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG_CYC);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule